// File: doc/BRIEF.md
# Pulse-Width Symbol Pattern Matcher

This block turns a stream of per-carrier-cycle amplitude decisions into pulse-width-coded symbols. An upstream detector supplies one bit per carrier cycle: high for the strong amplitude and low for the weak one, with a strobe that marks each cycle. A symbol takes ten such cycles, so a 1 kHz carrier yields 100 symbols per second. A separate marker input tells the block which cycle opens a symbol window.

Each complete window is compared bit by bit with three fixed templates, one per symbol kind. All three have a high run followed by a low run and differ only in the length of the high run: two cycles for a zero, five for a one and eight for a position marker. The agreement count with each template becomes a score. The best-scoring template is reported as the decoded symbol, so a window with a single corrupted cycle still decodes correctly. When two position markers arrive back to back, the block flags a frame start.

Top module: `pw_symbol_matcher`

## Requirements
- R1: While reset is applied, and until the first symbol completes, `sym_valid` and `frame_start` are 0, `sym_code` is 00 and `sym_score` is 0.
- R2: After reset, cycle bits are ignored until `sym_start` is seen together with `cyc_valid`. No `sym_valid` pulse occurs before that point, however many bits arrive.
- R3: A cycle carrying both `sym_start` and `cyc_valid` becomes the first cycle of a new window, and any partly collected window is dropped. A `sym_start` without `cyc_valid` has no effect.
- R4: Only cycles with `cyc_valid` high count. `sym_valid` pulses for exactly one clock, in the clock after the tenth counted cycle. Later windows follow back to back without a further `sym_start`.
- R5: The templates list cycles in arrival order. Zero is 1100000000 (code 00), one is 1111100000 (code 01) and position marker is 1111111100 (code 10). Code 11 never appears.
- R6: `sym_score` is 10 minus the number of cycles in which the window differs from the winning template, and no template agrees with the window in more cycles.
- R7: On equal scores, one is chosen over zero, and zero is chosen over position marker. For example, window 1100011100 decodes as zero with score 7.
- R8: A single wrong cycle is tolerated. Window 1101100000 decodes as one with score 9.
- R9: `frame_start` pulses together with `sym_valid` when the current symbol and the symbol before it are both position markers. It is 0 at all other times.
- R10: Between pulses, `sym_code` and `sym_score` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cyc_valid | input | 1 | The current clock carries one carrier-cycle decision |
| cyc_hi | input | 1 | Decision for that cycle: 1 for high amplitude, 0 for low |
| sym_start | input | 1 | The current cycle opens a symbol window (used only when cyc_valid is high) |
| sym_valid | output | 1 | One-clock pulse when a symbol has been decided |
| sym_code | output | 2 | Decoded symbol: 00 zero, 01 one, 10 position marker |
| sym_score | output | 4 | Agreement count of the winning template (0 to 10) |
| frame_start | output | 1 | Pulses with sym_valid on the second of two consecutive position markers |

## Verification
A cycle counter that is off by one shifts every later window. The error shows up at the latest on the next pulse: `sym_valid` arrives a cycle early or late, and the codes and scores of patterns that should be exact (score 10) come out wrong. A wrong tie order or a wrong score only becomes visible on windows built for it, so the bench feeds a near-tie, a single-error window and equal-score windows. A stale previous-symbol flag shows as a missing or extra `frame_start` on the very next position marker.

// File: rtl/pwsm_pkg.sv
package pwsm_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_POS  = 2'b10
  } sym_code_e;

  localparam int NUM_TMPL = 3;

endpackage

// File: rtl/pwsm_window.sv
module pwsm_window #(
  parameter int CYC = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_valid,
  input  logic           cyc_hi,
  input  logic           sym_start,
  output logic [CYC-1:0] win,
  output logic           win_done
);

  localparam int IDXW = $clog2(CYC);
  localparam logic [IDXW-1:0] LAST = IDXW'(CYC - 1);

  logic [CYC-2:0]  hist_q, hist_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            aligned_q, aligned_d;

  logic            take;
  logic            restart;
  logic [IDXW-1:0] pos_now;

  always_comb begin
    restart   = cyc_valid & sym_start;
    take      = cyc_valid & (sym_start | aligned_q);
    pos_now   = restart ? '0 : idx_q;
    win       = {hist_q, cyc_hi};
    win_done  = take & (pos_now == LAST);
    hist_d    = hist_q;
    idx_d     = idx_q;
    aligned_d = aligned_q | restart;
    if (take) begin
      hist_d = {hist_q[CYC-3:0], cyc_hi};
      idx_d  = win_done ? '0 : IDXW'(pos_now + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      idx_q     <= '0;
      aligned_q <= 1'b0;
    end else begin
      hist_q    <= hist_d;
      idx_q     <= idx_d;
      aligned_q <= aligned_d;
    end
  end

  // R4: the cycle index always stays inside one window
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDXW'(CYC));

  // R2: nothing is collected before the first alignment marker
  p_idle_unaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned_q && !sym_start) |=> (idx_q == $past(idx_q)));

endmodule

// File: rtl/pwsm_score.sv
module pwsm_score #(
  parameter int CYC = 10,
  parameter int HI  = 2,
  parameter int SW  = 4
) (
  input  logic [CYC-1:0] win,
  output logic [SW-1:0]  score
);

  logic [CYC-1:0] tmpl;
  logic [CYC-1:0] diff;

  // first arrived cycle sits in the MSB, so the high run fills the top bits
  for (genvar j = 0; j < CYC; j++) begin : g_tmpl
    assign tmpl[j] = ((CYC - 1 - j) < HI);
  end

  always_comb begin
    int miss;
    diff = win ^ tmpl;
    miss = 0;
    for (int k = 0; k < CYC; k++) begin
      miss = miss + int'(diff[k]);
    end
    score = SW'(CYC - miss);
  end

endmodule

// File: rtl/pwsm_decide.sv
module pwsm_decide
  import pwsm_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_done,
  input  logic [SW-1:0] sc_zero,
  input  logic [SW-1:0] sc_one,
  input  logic [SW-1:0] sc_pos,
  output logic          sym_valid,
  output logic [1:0]    sym_code,
  output logic [SW-1:0] sym_score,
  output logic          frame_start
);

  sym_code_e     best_code;
  logic [SW-1:0] best_score;

  logic          valid_q, valid_d;
  sym_code_e     code_q, code_d;
  logic [SW-1:0] score_q, score_d;
  logic          prev_pos_q, prev_pos_d;
  logic          frame_q, frame_d;

  always_comb begin
    if ((sc_one >= sc_zero) && (sc_one >= sc_pos)) begin
      best_code  = SYM_ONE;
      best_score = sc_one;
    end else if (sc_zero >= sc_pos) begin
      best_code  = SYM_ZERO;
      best_score = sc_zero;
    end else begin
      best_code  = SYM_POS;
      best_score = sc_pos;
    end
  end

  always_comb begin
    valid_d    = win_done;
    code_d     = code_q;
    score_d    = score_q;
    prev_pos_d = prev_pos_q;
    frame_d    = 1'b0;
    if (win_done) begin
      code_d     = best_code;
      score_d    = best_score;
      prev_pos_d = (best_code == SYM_POS);
      frame_d    = (best_code == SYM_POS) & prev_pos_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      code_q     <= SYM_ZERO;
      score_q    <= '0;
      prev_pos_q <= 1'b0;
      frame_q    <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      code_q     <= code_d;
      score_q    <= score_d;
      prev_pos_q <= prev_pos_d;
      frame_q    <= frame_d;
    end
  end

  assign sym_valid   = valid_q;
  assign sym_code    = code_q;
  assign sym_score   = score_q;
  assign frame_start = frame_q;

  // R4: one pulse per completed window, in the following clock
  p_pulse_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> sym_valid);
  p_quiet_without_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_done |=> !sym_valid);

  // R5: the unused code never leaves the block
  p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (sym_code != 2'b11));

  // R6: the reported score is the best of the three
  p_best_score_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> ((sym_score >= $past(sc_zero)) && (sym_score >= $past(sc_one))
                  && (sym_score >= $past(sc_pos))));

  // R9: frame flag only rides on a position marker pulse
  p_frame_on_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (sym_valid && (sym_code == SYM_POS)));

  // R10: result holds between pulses
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !win_done |=> ($stable(sym_code) && $stable(sym_score)));

endmodule

// File: rtl/pw_symbol_matcher.sv
module pw_symbol_matcher
  import pwsm_pkg::*;
#(
  parameter int CYC_PER_SYM = 10,
  parameter int ZERO_HI     = 2,
  parameter int ONE_HI      = 5,
  parameter int POS_HI      = 8,
  parameter int SCORE_W     = $clog2(CYC_PER_SYM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_valid,
  input  logic               cyc_hi,
  input  logic               sym_start,
  output logic               sym_valid,
  output logic [1:0]         sym_code,
  output logic [SCORE_W-1:0] sym_score,
  output logic               frame_start
);

  localparam int HI_TAB [NUM_TMPL] = '{ZERO_HI, ONE_HI, POS_HI};

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [CYC_PER_SYM-1:0] win;
  logic                   win_done;
  logic [SCORE_W-1:0]     sc [NUM_TMPL];

  pwsm_window #(.CYC(CYC_PER_SYM)) u_window (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cyc_valid(cyc_valid),
    .cyc_hi   (cyc_hi),
    .sym_start(sym_start),
    .win      (win),
    .win_done (win_done)
  );

  // index order follows the code values: zero, one, position marker
  for (genvar g = 0; g < NUM_TMPL; g++) begin : g_score
    pwsm_score #(.CYC(CYC_PER_SYM), .HI(HI_TAB[g]), .SW(SCORE_W)) u_score (
      .win  (win),
      .score(sc[g])
    );
  end

  pwsm_decide #(.SW(SCORE_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .win_done   (win_done),
    .sc_zero    (sc[0]),
    .sc_one     (sc[1]),
    .sc_pos     (sc[2]),
    .sym_valid  (sym_valid),
    .sym_code   (sym_code),
    .sym_score  (sym_score),
    .frame_start(frame_start)
  );

  // R1: outputs quiet while the synchronized reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_s |=> (!sym_valid && !frame_start));

endmodule

// File: tb/sim_pw_symbol_matcher.sv
`timescale 1ns/1ps
module sim_pw_symbol_matcher;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_valid, cyc_hi, sym_start;
  logic       sym_valid, frame_start;
  logic [1:0] sym_code;
  logic [3:0] sym_score;

  int n_chk  = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pw_symbol_matcher u0 (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_hi(cyc_hi),
    .sym_start(sym_start), .sym_valid(sym_valid), .sym_code(sym_code),
    .sym_score(sym_score), .frame_start(frame_start)
  );

  localparam int NV = 13;
  localparam logic [9:0] V_WIN [NV] = '{
    10'b1100000000, 10'b1111100000, 10'b1111111100, 10'b1101100000,
    10'b1100011100, 10'b0000000000, 10'b1111111111, 10'b1110000000,
    10'b1111110000, 10'b1111111000, 10'b1111111110, 10'b1111111100,
    10'b0101010101};
  localparam int V_CODE [NV] = '{0, 1, 2, 1, 0, 0, 2, 0, 1, 2, 2, 2, 0};
  localparam int V_SCORE[NV] = '{10, 10, 10, 9, 7, 8, 8, 9, 9, 9, 9, 10, 5};
  localparam int V_FRM  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic h, input logic s);
    cyc_valid = v; cyc_hi = h; sym_start = s;
    @(negedge clk); #1;
    cyc_valid = 1'b0; cyc_hi = 1'b0; sym_start = 1'b0;
    if (sym_valid) pulses++;
  endtask

  task automatic send_win(input logic [9:0] w, input bit first_start, input bit gaps);
    for (int b = 0; b < 10; b++) begin
      if (gaps && b[0]) step(1'b0, 1'b1, 1'b0);
      step(1'b1, w[9-b], first_start && (b == 0));
    end
  endtask

  initial begin
    int base;
    cyc_valid = 1'b0; cyc_hi = 1'b0; sym_start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid in reset", int'(sym_valid), 0);
    chk("R1 frame in reset", int'(frame_start), 0);
    chk("R1 code in reset", int'(sym_code), 0);
    chk("R1 score in reset", int'(sym_score), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    // R2: bits before any start marker are ignored
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0);
    chk("R2 no pulse before start", pulses, 0);

    // table walk: R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      base = pulses;
      for (int b = 0; b < 10; b++) begin
        if (v[0] && b[0]) step(1'b0, 1'b1, 1'b0);
        step(1'b1, V_WIN[v][9-b], (v == 0) && (b == 0));
        if (b == 8) chk("R4 no early pulse", int'(sym_valid), 0);
      end
      chk("R4 pulse after tenth", int'(sym_valid), 1);
      chk("R4 single pulse", pulses - base, 1);
      chk("R5 code", int'(sym_code), V_CODE[v]);
      chk("R6 score", int'(sym_score), V_SCORE[v]);
      chk("R9 frame flag", int'(frame_start), V_FRM[v]);
    end

    // R3: restart mid-window, drop partial bits
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    base = pulses;
    send_win(10'b1111111100, 1'b1, 1'b0);
    chk("R3 restart single pulse", pulses - base, 1);
    chk("R3 restart code", int'(sym_code), 2);
    chk("R3 restart score", int'(sym_score), 10);
    chk("R9 no frame after zero", int'(frame_start), 0);

    // R3: start without valid ignored; R9 second marker gives frame
    base = pulses;
    for (int b = 0; b < 10; b++) begin
      if (b == 4) step(1'b0, 1'b0, 1'b1);
      step(1'b1, (b < 8), 1'b0);
    end
    chk("R3 start without valid ignored", pulses - base, 1);
    chk("R9 frame on second marker", int'(frame_start), 1);
    chk("R8 R7 code held", int'(sym_code), 2);

    // R10: hold between pulses
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1);
    chk("R10 valid low while idle", int'(sym_valid), 0);
    chk("R10 frame low while idle", int'(frame_start), 0);
    chk("R10 code held", int'(sym_code), 2);
    chk("R10 score held", int'(sym_score), 10);

    // R7 R8 directed after gaps
    send_win(10'b1100011100, 1'b0, 1'b1);
    chk("R7 tie prefers zero", int'(sym_code), 0);
    send_win(10'b1101100000, 1'b0, 1'b0);
    chk("R8 single error to one", int'(sym_code), 1);
    chk("R8 single error score", int'(sym_score), 9);

    // R1: reset mid-stream clears outputs
    rst_n = 1'b0;
    #1;
    chk("R1 code cleared", int'(sym_code), 0);
    chk("R1 score cleared", int'(sym_score), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule